// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over 16-bit Management Accesses

This block sits on the slave side of a 16-bit management access port that uses PHY-address and register-number addressing. Behind it is a register space of 32-bit words. A 16-bit management access can reach only part of a word index, so the bridge keeps a page register that holds the upper index bits. The remaining index bits are folded into the PHY address and register number of ordinary accesses. Each pair of adjacent register numbers maps to one 32-bit word. The even register carries the low half and the odd register the high half.

Software first writes the page. A 32-bit write is then two accesses: the high half goes to the odd register and is held in a staging register, and the low half goes to the even register and commits the whole word. A 32-bit read is also two accesses. The low-half read fetches the whole word and keeps its upper half. The high-half read then returns the kept half, so both halves always come from the same word. The register file is reached through a plain 32-bit read/write port. Its address and strobes are combinational from the current access, and its read data is sampled at the end of that cycle.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, `acc_rdata` is 0x0000, `acc_rvalid` is 0, the page register is 0 and the staging register is 0.
- R2: A write to PHY address 0x1F, register 0x10 loads the page register with `acc_wdata[8:0]`. A read of that same location returns the page zero-extended to 16 bits.
- R3: For an access to PHY addresses 0x10 to 0x17, the word index on `rf_addr` is {page[8:0], acc_phy[2:0], acc_reg[4:1]}. The register file's byte address is this index times four.
- R4: A write to an odd register (acc_reg[0]=1) inside the window only loads the staging register with `acc_wdata`. It raises no `rf_wr_en`.
- R5: A write to an even register inside the window raises `rf_wr_en` for that cycle, with `rf_wdata` = {staging, acc_wdata}. The staging register keeps its value afterwards.
- R6: A read of an even register inside the window raises `rf_rd_en`. One cycle later `acc_rdata` is `rf_rdata[15:0]`, and `rf_rdata[31:16]` is held in a latch.
- R7: A read of an odd register inside the window returns the latched upper half. It raises no `rf_rd_en`, so the result is not affected by any change to the word after the low-half read.
- R8: Accesses to PHY addresses outside 0x10 to 0x17 and other than 0x1F raise no register-file strobe and leave the page unchanged. Reads of those addresses return 0xFFFF.
- R9: Accesses to PHY address 0x1F at any register other than 0x10 are ignored in the same way, and reads of them return 0xFFFF.
- R10: `acc_rvalid` is high for exactly the one cycle after each read access, whatever the address, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A management access is presented this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_phy | input | 5 | PHY address of the access |
| acc_reg | input | 5 | Register number of the access |
| acc_wdata | input | 16 | Write data of the access |
| acc_rdata | output | 16 | Read data, valid while `acc_rvalid` is high and held until the next read |
| acc_rvalid | output | 1 | Read response pulse, one cycle after a read access |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_addr | output | 16 | Register-file word index |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data for `rf_addr`, sampled at the clock edge |

## Verification
A wrong page value or a wrong index fold shows at once on `rf_addr` during the access that uses it. It also shows one cycle later in the low-half read data, because the modelled register file returns a value derived from its address. A staging register that is lost or overwritten corrupts the upper 16 bits of `rf_wdata` on the next even-register write. A broken upper-half latch shows on the following odd-register read, including the case where the word changes between the two halves. A decode that leaks outside the window shows in the same cycle as a stray strobe, or one cycle later as read data other than 0xFFFF.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  // One-hot classification of the current management access.
  typedef struct packed {
    logic page_wr;  // write to the page register
    logic page_rd;  // read of the page register
    logic hi_wr;    // windowed write, odd register (upper half)
    logic lo_wr;    // windowed write, even register (lower half)
    logic lo_rd;    // windowed read, even register
    logic hi_rd;    // windowed read, odd register
    logic miss_rd;  // read of an unmapped location
  } mpb_dec_t;

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode #(
  parameter int unsigned           PHY_W    = 5,
  parameter int unsigned           REG_W    = 5,
  parameter int unsigned           SEL_W    = 3,
  parameter logic [PHY_W-1:0]      PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0]      PAGE_REG = 5'h10,
  parameter logic [PHY_W-1:0]      WIN_BASE = 5'h10
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [PHY_W-1:0] acc_phy,
  input  logic [REG_W-1:0] acc_reg,
  output mpb_pkg::mpb_dec_t dec
);
  localparam int unsigned TAG_W = PHY_W - SEL_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[PHY_W-1:SEL_W];

  logic win_hit;
  logic page_hit;

  assign win_hit  = (acc_phy[PHY_W-1:SEL_W] == WIN_TAG);
  assign page_hit = (acc_phy == PAGE_PHY);

  always_comb begin
    dec = '0;
    if (acc_valid) begin
      if (page_hit) begin
        if (acc_reg == PAGE_REG) begin
          dec.page_wr = acc_write;
          dec.page_rd = !acc_write;
        end else begin
          dec.miss_rd = !acc_write;
        end
      end else if (win_hit) begin
        if (acc_reg[0]) begin
          dec.hi_wr = acc_write;
          dec.hi_rd = !acc_write;
        end else begin
          dec.lo_wr = acc_write;
          dec.lo_rd = !acc_write;
        end
      end else begin
        dec.miss_rd = !acc_write;
      end
    end
  end

endmodule

// File: rtl/mpb_page.sv
module mpb_page #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_wr,
  input  logic [HALF_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] page_d;
  logic              page_en;
  logic              unused_hi;

  assign unused_hi = ^wr_data[HALF_W-1:PAGE_W];

  always_comb begin
    page_en = page_wr;
    page_d  = wr_data[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_en) begin
      page_q <= page_d;
    end
  end

  // R2
  page_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr |=> $stable(page_q));

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> (page_q == $past(wr_data[PAGE_W-1:0])));

endmodule

// File: rtl/mpb_wr_stage.sv
module mpb_wr_stage #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                rf_wr_en,
  output logic [2*HALF_W-1:0] rf_wdata
);
  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] stage_d;
  logic              stage_en;

  always_comb begin
    stage_en = hi_wr;
    stage_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign rf_wr_en = lo_wr;
  assign rf_wdata = {stage_q, wr_data};

  // R4
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(stage_q));

  // R5
  commit_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr ##1 lo_wr) |-> (rf_wdata[2*HALF_W-1:HALF_W] == $past(wr_data)));

endmodule

// File: rtl/mpb_rd_split.sv
module mpb_rd_split #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PAGE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_rd,
  input  logic                hi_rd,
  input  logic                page_rd,
  input  logic                miss_rd,
  input  logic [PAGE_W-1:0]   page_val,
  input  logic [2*HALF_W-1:0] rf_rdata,
  output logic [HALF_W-1:0]   acc_rdata,
  output logic                acc_rvalid
);
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] hi_d;
  logic              hi_en;
  logic [HALF_W-1:0] rdata_d;
  logic              rdata_en;
  logic              rvalid_d;

  always_comb begin
    hi_en    = lo_rd;
    hi_d     = rf_rdata[2*HALF_W-1:HALF_W];
    rvalid_d = lo_rd | hi_rd | page_rd | miss_rd;
    rdata_en = rvalid_d;
    rdata_d  = '1;
    if (lo_rd) begin
      rdata_d = rf_rdata[HALF_W-1:0];
    end else if (hi_rd) begin
      rdata_d = hi_q;
    end else if (page_rd) begin
      rdata_d = {{(HALF_W-PAGE_W){1'b0}}, page_val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q       <= '0;
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= rvalid_d;
      if (hi_en) begin
        hi_q <= hi_d;
      end
      if (rdata_en) begin
        acc_rdata <= rdata_d;
      end
    end
  end

  // R6
  lo_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (acc_rdata == $past(rf_rdata[HALF_W-1:0])));

  // R7
  hi_read_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (acc_rdata == $past(hi_q)));

  // R8
  miss_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_rd |=> (acc_rdata == {HALF_W{1'b1}}));

  // R10
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd || hi_rd || page_rd || miss_rd) |=> acc_rvalid);

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int unsigned      PHY_W    = 5,
  parameter int unsigned      REG_W    = 5,
  parameter int unsigned      HALF_W   = 16,
  parameter int unsigned      PAGE_W   = 9,
  parameter int unsigned      SEL_W    = 3,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
  localparam int unsigned     IDX_W    = REG_W - 1,
  localparam int unsigned     ADDR_W   = PAGE_W + SEL_W + IDX_W,
  localparam int unsigned     WORD_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [PHY_W-1:0]  acc_phy,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic [HALF_W-1:0] acc_wdata,
  output logic [HALF_W-1:0] acc_rdata,
  output logic              acc_rvalid,
  output logic              rf_wr_en,
  output logic              rf_rd_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  input  logic [WORD_W-1:0] rf_rdata
);
  mpb_pkg::mpb_dec_t dec;
  logic [PAGE_W-1:0] page_q;
  logic              in_window;
  logic              is_read;

  mpb_decode #(
    .PHY_W    (PHY_W),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W),
    .PAGE_PHY (PAGE_PHY),
    .PAGE_REG (PAGE_REG),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_phy   (acc_phy),
    .acc_reg   (acc_reg),
    .dec       (dec)
  );

  mpb_page #(
    .HALF_W (HALF_W),
    .PAGE_W (PAGE_W)
  ) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .page_wr (dec.page_wr),
    .wr_data (acc_wdata),
    .page_q  (page_q)
  );

  mpb_wr_stage #(
    .HALF_W (HALF_W)
  ) u_wr_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_wr    (dec.hi_wr),
    .lo_wr    (dec.lo_wr),
    .wr_data  (acc_wdata),
    .rf_wr_en (rf_wr_en),
    .rf_wdata (rf_wdata)
  );

  mpb_rd_split #(
    .HALF_W (HALF_W),
    .PAGE_W (PAGE_W)
  ) u_rd_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_rd      (dec.lo_rd),
    .hi_rd      (dec.hi_rd),
    .page_rd    (dec.page_rd),
    .miss_rd    (dec.miss_rd),
    .page_val   (page_q),
    .rf_rdata   (rf_rdata),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid)
  );

  // Word index: page above, window PHY select in the middle, register pair below.
  assign rf_addr  = {page_q, acc_phy[SEL_W-1:0], acc_reg[IDX_W:1]};
  assign rf_rd_en = dec.lo_rd;

  assign in_window = (acc_phy[PHY_W-1:SEL_W] == WIN_BASE[PHY_W-1:SEL_W]);
  assign is_read   = acc_valid && !acc_write;

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !in_window) |-> (!rf_wr_en && !rf_rd_en));

  // R7
  hi_read_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && acc_reg[0]) |-> !rf_rd_en);

  // R10
  rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(is_read));

  // R3
  addr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en || rf_rd_en) |-> (rf_addr[ADDR_W-1:ADDR_W-PAGE_W] == page_q));

endmodule

// File: tb/mdio_page_bridge_tb.sv
`timescale 1ns/1ps
module mdio_page_bridge_tb;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [4:0]  acc_phy;
  logic [4:0]  acc_reg;
  logic [15:0] acc_wdata;
  logic [15:0] acc_rdata;
  logic        acc_rvalid;
  logic        rf_wr_en;
  logic        rf_rd_en;
  logic [15:0] rf_addr;
  logic [31:0] rf_wdata;
  logic [31:0] rf_rdata;
  logic [31:0] salt;

  int n_checks;
  int n_fails;
  bit done;

  mdio_page_bridge u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_phy    (acc_phy),
    .acc_reg    (acc_reg),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .rf_wr_en   (rf_wr_en),
    .rf_rd_en   (rf_rd_en),
    .rf_addr    (rf_addr),
    .rf_wdata   (rf_wdata),
    .rf_rdata   (rf_rdata)
  );

  // Register file model: content is a fixed function of the word index.
  assign rf_rdata = {~rf_addr, rf_addr ^ 16'hA5C3} ^ salt;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    logic        exp_w;
    logic [15:0] exp_a;
    logic [31:0] exp_d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h1F, 5'h10, 16'h0123, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd2},  // R2 page = 0x123
    '{1'b0, 5'h1F, 5'h10, 16'h0000, 16'h0123, 1'b0, 16'h0000, 32'h0,        4'd2},  // R2 readback
    '{1'b1, 5'h15, 5'h07, 16'hBEEF, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd4},  // R4 stage only
    '{1'b1, 5'h15, 5'h06, 16'h1234, 16'h0000, 1'b1, 16'h91D3, 32'hBEEF1234, 4'd5},  // R5, R3
    '{1'b0, 5'h15, 5'h06, 16'h0000, 16'h3410, 1'b0, 16'h0000, 32'h0,        4'd6},  // R6
    '{1'b0, 5'h15, 5'h07, 16'h0000, 16'h6E2C, 1'b0, 16'h0000, 32'h0,        4'd7},  // R7
    '{1'b0, 5'h03, 5'h06, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 32'h0,        4'd8},  // R8 read
    '{1'b1, 5'h03, 5'h06, 16'h7777, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd8},  // R8 write
    '{1'b0, 5'h1F, 5'h11, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 32'h0,        4'd9},  // R9 read
    '{1'b1, 5'h1F, 5'h11, 16'h0055, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd9},  // R9 write
    '{1'b0, 5'h1F, 5'h10, 16'h0000, 16'h0123, 1'b0, 16'h0000, 32'h0,        4'd9},  // R9 page kept
    '{1'b1, 5'h1F, 5'h10, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd2},  // R2 truncation
    '{1'b0, 5'h1F, 5'h10, 16'h0000, 16'h01FF, 1'b0, 16'h0000, 32'h0,        4'd2},
    '{1'b0, 5'h10, 5'h00, 16'h0000, 16'h5A43, 1'b0, 16'h0000, 32'h0,        4'd3},  // R3 lowest
    '{1'b0, 5'h10, 5'h01, 16'h0000, 16'h007F, 1'b0, 16'h0000, 32'h0,        4'd7},
    '{1'b0, 5'h17, 5'h1E, 16'h0000, 16'h5A3C, 1'b0, 16'h0000, 32'h0,        4'd3},  // R3 highest
    '{1'b0, 5'h17, 5'h1F, 16'h0000, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd7},
    '{1'b1, 5'h17, 5'h1F, 16'hCAFE, 16'h0000, 1'b0, 16'h0000, 32'h0,        4'd4},
    '{1'b1, 5'h17, 5'h1E, 16'hF00D, 16'h0000, 1'b1, 16'hFFFF, 32'hCAFEF00D, 4'd5},
    '{1'b1, 5'h10, 5'h00, 16'h5555, 16'h0000, 1'b1, 16'hFF80, 32'hCAFE5555, 4'd5}   // R5 stage kept
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // One access: inputs driven at a falling edge, strobes sampled mid-cycle,
  // read response sampled at the following falling edge.
  task automatic access(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd,
                        output logic wen, output logic ren, output logic [15:0] wa,
                        output logic [31:0] wdo, output logic [15:0] rd, output logic rv);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_phy   = phy;
    acc_reg   = rg;
    acc_wdata = wd;
    #1;
    wen = rf_wr_en;
    ren = rf_rd_en;
    wa  = rf_addr;
    wdo = rf_wdata;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    rd = acc_rdata;
    rv = acc_rvalid;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic wen, ren, rv;
    logic [15:0] wa, rd;
    logic [31:0] wdo;
    n_checks = 0;
    n_fails  = 0;
    salt      = '0;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    acc_phy   = '0;
    acc_reg   = '0;
    acc_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(acc_rdata == 16'h0000, "R1", "rdata after reset", {16'h0, acc_rdata}, 32'h0);
    check(acc_rvalid == 1'b0, "R1", "rvalid after reset", {31'h0, acc_rvalid}, 32'h0);
    access(1'b0, 5'h1F, 5'h10, 16'h0, wen, ren, wa, wdo, rd, rv);
    check(rd == 16'h0000, "R1", "page after reset", {16'h0, rd}, 32'h0);
    // R1 staging is zero: low-half write right after reset
    access(1'b1, 5'h12, 5'h02, 16'hABCD, wen, ren, wa, wdo, rd, rv);
    check(wen && wdo == 32'h0000ABCD, "R1", "staging after reset", wdo, 32'h0000ABCD);
    check(wa == 16'h0021, "R3", "addr page 0", {16'h0, wa}, 32'h0021);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].phy, VEC[i].rg, VEC[i].wd, wen, ren, wa, wdo, rd, rv);
      if (VEC[i].wr) begin
        check(wen == VEC[i].exp_w, $sformatf("R%0d", VEC[i].req),
              $sformatf("vec %0d wr_en", i), {31'h0, wen}, {31'h0, VEC[i].exp_w});
        if (VEC[i].exp_w) begin
          check(wa == VEC[i].exp_a, $sformatf("R%0d", VEC[i].req),
                $sformatf("vec %0d addr", i), {16'h0, wa}, {16'h0, VEC[i].exp_a});
          check(wdo == VEC[i].exp_d, $sformatf("R%0d", VEC[i].req),
                $sformatf("vec %0d wdata", i), wdo, VEC[i].exp_d);
        end
        check(!ren, $sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rd_en on write", i),
              {31'h0, ren}, 32'h0);
      end else begin
        check(!wen, $sformatf("R%0d", VEC[i].req), $sformatf("vec %0d wr_en on read", i),
              {31'h0, wen}, 32'h0);
        check(rv == 1'b1, "R10", $sformatf("vec %0d rvalid", i), {31'h0, rv}, 32'h1);
        check(rd == VEC[i].exp_rd, $sformatf("R%0d", VEC[i].req),
              $sformatf("vec %0d rdata", i), {16'h0, rd}, {16'h0, VEC[i].exp_rd});
      end
    end

    // R10 pulse lasts one cycle only
    @(negedge clk);
    check(acc_rvalid == 1'b0, "R10", "rvalid after idle", {31'h0, acc_rvalid}, 32'h0);

    // R7 coherency: word changes between halves, high half keeps the old value
    access(1'b1, 5'h1F, 5'h10, 16'h0000, wen, ren, wa, wdo, rd, rv);
    access(1'b0, 5'h11, 5'h04, 16'h0, wen, ren, wa, wdo, rd, rv);
    check(ren && wa == 16'h0012, "R6", "lo read strobe/addr", {15'h0, ren, wa}, 32'h10012);
    check(rd == 16'hA5D1, "R6", "lo read data", {16'h0, rd}, 32'hA5D1);
    salt = 32'hFFFF_FFFF;
    access(1'b0, 5'h11, 5'h05, 16'h0, wen, ren, wa, wdo, rd, rv);
    check(!ren, "R7", "no fetch on hi read", {31'h0, ren}, 32'h0);
    check(rd == 16'hFFED, "R7", "hi read coherent", {16'h0, rd}, 32'hFFED);
    salt = '0;

    // R8 outside write leaves staging intact, R4 hi write then outside then lo
    access(1'b1, 5'h11, 5'h05, 16'h1357, wen, ren, wa, wdo, rd, rv);
    check(!wen, "R4", "hi write no strobe", {31'h0, wen}, 32'h0);
    access(1'b1, 5'h08, 5'h05, 16'h9999, wen, ren, wa, wdo, rd, rv);
    check(!wen && !ren, "R8", "outside write quiet", {30'h0, wen, ren}, 32'h0);
    access(1'b1, 5'h11, 5'h04, 16'h2468, wen, ren, wa, wdo, rd, rv);
    check(wdo == 32'h13572468, "R8", "staging untouched by outside write", wdo, 32'h13572468);

    // R1 asynchronous reset mid-run clears page and read data
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(acc_rdata == 16'h0 && acc_rvalid == 1'b0, "R1", "async reset outputs",
          {15'h0, acc_rvalid, acc_rdata}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 5'h1F, 5'h10, 16'h0, wen, ren, wa, wdo, rd, rv);
    check(rd == 16'h0000, "R1", "page after second reset", {16'h0, rd}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule